// File: doc/BRIEF.md
# Write-Once Snooping Cache Line Controller

This block keeps coherence for a small direct-mapped cache that sits beside other caches of the same kind on one shared bus. Each line holds one word and is in one of three states: INVALID, CLEAN or DIRTY. The first write to a line goes out on the bus as a read-for-ownership, which invalidates every other copy. After that the line is DIRTY, so later writes by the same processor stay inside the cache and cause no bus traffic. Memory is not updated while a line is DIRTY.

The block watches the bus through a snoop port. When another cache reads or writes a line that this cache holds DIRTY, the block answers on its own. It drives the line's data, raises a supply flag so that the bus gives this data instead of memory's copy, and invalidates its own line. The requester then installs the line as DIRTY, so ownership moves from cache to cache without passing through memory. If the frame is needed for another address, a DIRTY victim is written back to memory first. A CLEAN victim is dropped with no bus traffic.

The bus agent outside the block does the arbitration. It broadcasts each transaction to the snoop ports of all other caches. It answers the requester with `bus_done` and the data, and it sets `bus_from_cache` when the data came from a cache and not from memory.

Top module: `wo_snoop_ctrl`

## Requirements
- R1: After reset every line is INVALID: `cpu_lstate` reads 0 for every address, and `bus_req` and `cpu_ready` are low.
- R2: A read that misses, with no DIRTY holder on the bus, issues exactly one transaction with `bus_op` = 1 (read). It returns memory's data and leaves the line CLEAN (`cpu_lstate` = 1).
- R3: A cache holding a line CLEAN that snoops a read (op 1) of that line keeps `snp_supply` low and stays CLEAN.
- R4: A write to a line that is CLEAN or INVALID issues one transaction with `bus_op` = 2 (read-for-ownership) and leaves the line DIRTY (`cpu_lstate` = 2). No write-back (op 3) is issued, and memory keeps its old value.
- R5: A cache holding a line CLEAN that snoops op 2 for that line moves it to INVALID.
- R6: A write to a DIRTY line completes in the cycle it is requested, with no bus transaction.
- R7: A cache holding a line DIRTY that snoops op 1 or op 2 for it raises `snp_supply`, drives the line data on `snp_data` and moves to INVALID. A requester whose fill has `bus_from_cache` set installs the line DIRTY, whether it asked to read or to write.
- R8: The frame is chosen by the low log2(NL) address bits. A miss on a frame that holds a different DIRTY address first issues op 3 with the old address and data, then the fill. A CLEAN victim is replaced with no op 3.
- R9: In a cycle with `snp_valid` high, a pending local request does not complete. It completes in the next cycle without the snoop.
- R10: A read hit completes in the cycle it is requested, returns the line data and uses no bus transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Read data, valid with `cpu_ready` |
| cpu_lstate | output | 2 | State of the line at `cpu_addr`: 0 INVALID, 1 CLEAN, 2 DIRTY |
| bus_req | output | 1 | Bus transaction pending |
| bus_op | output | 2 | 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write-back data |
| bus_done | input | 1 | Transaction finishes this cycle |
| bus_rdata | input | DW | Fill data |
| bus_from_cache | input | 1 | Fill data came from another cache |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_op | input | 2 | Snooped operation, same codes as `bus_op` |
| snp_addr | input | AW | Snooped address |
| snp_supply | output | 1 | This cache gives the data and memory must not answer |
| snp_data | output | DW | Data given on intervention |

## Verification
The hardest case to reach is ownership moving from cache to cache. To get there, one cache must first own a word DIRTY, and then a second cache must request that word while the bench routes the second cache's transaction into the owner's snoop port in the same cycle. The bench acts as the bus and memory for three instances. It replays the shared-word story: one reader, a second reader, a write, a repeated write, then a third-party read and write. It then sweeps writer and reader pairs over many addresses, so that intervention and dirty evictions overlap in shared frames. Snoop priority is tested by raising an unrelated snoop in the very cycle a local hit is requested.

// File: rtl/wo_coh_pkg.sv
`timescale 1ns/1ps
package wo_coh_pkg;
  typedef enum logic [1:0] {LN_INV = 2'd0, LN_CLN = 2'd1, LN_DRT = 2'd2} line_st_e;
  typedef enum logic [1:0] {BOP_NONE = 2'd0, BOP_RD = 2'd1, BOP_RDX = 2'd2, BOP_WB = 2'd3} bus_op_e;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_WB = 2'd1, F_FILL = 2'd2} fsm_e;

  // state after observing a remote transaction
  function automatic line_st_e snoop_next(line_st_e s, bus_op_e op);
    line_st_e r = s;
    if (s == LN_DRT && (op == BOP_RD || op == BOP_RDX)) r = LN_INV;
    if (s == LN_CLN && op == BOP_RDX) r = LN_INV;
    return r;
  endfunction

  // a dirty owner answers any remote read or ownership read
  function automatic logic snoop_supplies(line_st_e s, bus_op_e op);
    return (s == LN_DRT) && (op == BOP_RD || op == BOP_RDX);
  endfunction

  // state installed by a finished fill
  function automatic line_st_e fill_state(logic we, logic from_cache);
    return (we || from_cache) ? LN_DRT : LN_CLN;
  endfunction

  // a hit that needs no bus
  function automatic logic local_only(logic we, line_st_e s);
    return (s != LN_INV) && (!we || s == LN_DRT);
  endfunction
endpackage

// File: rtl/wo_line_array.sv
`timescale 1ns/1ps
module wo_line_array
  import wo_coh_pkg::*;
#(
  parameter int NL = 4,
  parameter int TW = 6,
  parameter int DW = 16,
  localparam int IW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] c_idx,
  output logic [TW-1:0] c_tag,
  output line_st_e      c_st,
  output logic [DW-1:0] c_data,
  input  logic [IW-1:0] s_idx,
  output logic [TW-1:0] s_tag,
  output line_st_e      s_st,
  output logic [DW-1:0] s_data,
  input  logic          lw_en,
  input  logic [TW-1:0] lw_tag,
  input  line_st_e      lw_st,
  input  logic          lw_data_en,
  input  logic [DW-1:0] lw_data,
  input  logic          sw_en,
  input  line_st_e      sw_st
);
  logic [TW-1:0] tag_a [NL];
  line_st_e      st_a  [NL];
  logic [DW-1:0] dat_a [NL];

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [TW-1:0] tag_r;
    line_st_e      st_r;
    logic [DW-1:0] dat_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_r <= '0;
        st_r  <= LN_INV;
        dat_r <= '0;
      end else begin
        if (lw_en && c_idx == IW'(g)) begin
          tag_r <= lw_tag;
          st_r  <= lw_st;
          if (lw_data_en) dat_r <= lw_data;
        end
        // snoop update is written last so it wins on the same line
        if (sw_en && s_idx == IW'(g)) st_r <= sw_st;
      end
    end
    assign tag_a[g] = tag_r;
    assign st_a[g]  = st_r;
    assign dat_a[g] = dat_r;
  end

  assign c_tag  = tag_a[c_idx];
  assign c_st   = st_a[c_idx];
  assign c_data = dat_a[c_idx];
  assign s_tag  = tag_a[s_idx];
  assign s_st   = st_a[s_idx];
  assign s_data = dat_a[s_idx];
endmodule

// File: rtl/wo_snoop_unit.sv
`timescale 1ns/1ps
module wo_snoop_unit
  import wo_coh_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 2,
  localparam int TW = AW - IW
) (
  input  logic          snp_valid,
  input  bus_op_e       snp_op,
  input  logic [AW-1:0] snp_addr,
  output logic [IW-1:0] s_idx,
  input  logic [TW-1:0] s_tag,
  input  line_st_e      s_st,
  output logic          s_hit,
  output logic          supply,
  output logic          upd_en,
  output line_st_e      upd_st
);
  assign s_idx  = snp_addr[IW-1:0];
  assign s_hit  = snp_valid && (s_st != LN_INV) && (s_tag == snp_addr[AW-1:IW]);
  assign supply = s_hit && snoop_supplies(s_st, snp_op);
  assign upd_st = snoop_next(s_st, snp_op);
  assign upd_en = s_hit && (upd_st != s_st);
endmodule

// File: rtl/wo_local_fsm.sv
`timescale 1ns/1ps
module wo_local_fsm
  import wo_coh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cpu_req,
  input  logic     cpu_we,
  input  line_st_e c_st,
  input  logic     tag_match,
  input  logic     snp_valid,
  input  logic     bus_done,
  input  logic     bus_from_cache,
  output logic     cpu_ready,
  output logic     bus_req,
  output bus_op_e  bus_op,
  output logic     lw_en,
  output line_st_e lw_st,
  output logic     lw_newtag,
  output logic     lw_data_en,
  output logic     lw_sel_cpu,
  output logic     fsm_idle,
  output logic     ev_hit_done,
  output logic     ev_local_write_hit,
  output logic     ev_wb_done,
  output logic     ev_fill_done
);
  fsm_e cur, nxt;
  logic hit;

  assign hit = (c_st != LN_INV) && tag_match;

  always_comb begin
    nxt        = cur;
    cpu_ready  = 1'b0;
    bus_req    = 1'b0;
    bus_op     = BOP_NONE;
    lw_en      = 1'b0;
    lw_st      = c_st;
    lw_newtag  = 1'b0;
    lw_data_en = 1'b0;
    lw_sel_cpu = 1'b0;
    unique case (cur)
      F_IDLE: begin
        if (cpu_req && !snp_valid) begin
          if (hit && local_only(cpu_we, c_st)) begin
            cpu_ready = 1'b1;
            if (cpu_we) begin
              lw_en      = 1'b1;
              lw_data_en = 1'b1;
              lw_sel_cpu = 1'b1;
            end
          end else if (!hit && c_st == LN_DRT) begin
            nxt = F_WB;
          end else begin
            nxt = F_FILL;
          end
        end
      end
      F_WB: begin
        bus_req = 1'b1;
        bus_op  = BOP_WB;
        if (bus_done) begin
          lw_en = 1'b1;
          lw_st = LN_INV;
          nxt   = F_IDLE;
        end
      end
      F_FILL: begin
        bus_req = 1'b1;
        bus_op  = cpu_we ? BOP_RDX : BOP_RD;
        if (bus_done) begin
          cpu_ready  = 1'b1;
          lw_en      = 1'b1;
          lw_st      = fill_state(cpu_we, bus_from_cache);
          lw_newtag  = 1'b1;
          lw_data_en = 1'b1;
          lw_sel_cpu = cpu_we;
          nxt        = F_IDLE;
        end
      end
      default: nxt = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= F_IDLE;
    else        cur <= nxt;
  end

  assign fsm_idle           = (cur == F_IDLE);
  assign ev_hit_done        = fsm_idle && cpu_ready;
  assign ev_local_write_hit = ev_hit_done && cpu_we;
  assign ev_wb_done         = (cur == F_WB) && bus_done;
  assign ev_fill_done       = (cur == F_FILL) && bus_done;
endmodule

// File: rtl/wo_snoop_ctrl.sv
`timescale 1ns/1ps
module wo_snoop_ctrl
  import wo_coh_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic [1:0]    cpu_lstate,
  output logic          bus_req,
  output logic [1:0]    bus_op,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_done,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_from_cache,
  input  logic          snp_valid,
  input  logic [1:0]    snp_op,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_supply,
  output logic [DW-1:0] snp_data
);
  localparam int IW = $clog2(NL);
  localparam int TW = AW - IW;

  logic [IW-1:0] c_idx, s_idx;
  logic [TW-1:0] c_tag, s_tag, c_tag_in, lw_tag;
  line_st_e      c_st, s_st, lw_st, snp_next_st;
  logic [DW-1:0] c_data, s_data, lw_data;
  logic          tag_match, lw_en, lw_newtag, lw_data_en, lw_sel_cpu;
  logic          fsm_idle, ev_hit_done, ev_local_write_hit, ev_wb_done, ev_fill_done;
  logic          snp_hit, snp_upd_en;
  bus_op_e       op_e;

  assign c_idx     = cpu_addr[IW-1:0];
  assign c_tag_in  = cpu_addr[AW-1:IW];
  assign tag_match = (c_tag == c_tag_in);

  wo_line_array #(.NL(NL), .TW(TW), .DW(DW)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .c_idx(c_idx), .c_tag(c_tag), .c_st(c_st), .c_data(c_data),
    .s_idx(s_idx), .s_tag(s_tag), .s_st(s_st), .s_data(s_data),
    .lw_en(lw_en), .lw_tag(lw_tag), .lw_st(lw_st),
    .lw_data_en(lw_data_en), .lw_data(lw_data),
    .sw_en(snp_upd_en), .sw_st(snp_next_st)
  );

  wo_snoop_unit #(.AW(AW), .IW(IW)) u_snoop (
    .snp_valid(snp_valid), .snp_op(bus_op_e'(snp_op)), .snp_addr(snp_addr),
    .s_idx(s_idx), .s_tag(s_tag), .s_st(s_st),
    .s_hit(snp_hit), .supply(snp_supply),
    .upd_en(snp_upd_en), .upd_st(snp_next_st)
  );

  wo_local_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we),
    .c_st(c_st), .tag_match(tag_match),
    .snp_valid(snp_valid), .bus_done(bus_done), .bus_from_cache(bus_from_cache),
    .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_op(op_e),
    .lw_en(lw_en), .lw_st(lw_st), .lw_newtag(lw_newtag),
    .lw_data_en(lw_data_en), .lw_sel_cpu(lw_sel_cpu),
    .fsm_idle(fsm_idle), .ev_hit_done(ev_hit_done),
    .ev_local_write_hit(ev_local_write_hit),
    .ev_wb_done(ev_wb_done), .ev_fill_done(ev_fill_done)
  );

  assign lw_tag     = lw_newtag ? c_tag_in : c_tag;
  assign lw_data    = lw_sel_cpu ? cpu_wdata : bus_rdata;
  assign bus_op     = op_e;
  assign bus_addr   = (op_e == BOP_WB) ? {c_tag, c_idx} : cpu_addr;
  assign bus_wdata  = c_data;
  assign cpu_rdata  = fsm_idle ? c_data : bus_rdata;
  assign cpu_lstate = (c_st != LN_INV && tag_match) ? c_st : LN_INV;
  assign snp_data   = s_data;
endmodule

// File: rtl/wo_snoop_ctrl_chk.sv
`timescale 1ns/1ps
module wo_snoop_ctrl_chk #(
  parameter int AW = 8,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_ready,
  input logic [1:0]    cpu_lstate,
  input logic          bus_req,
  input logic [1:0]    bus_op,
  input logic [AW-1:0] bus_addr,
  input logic          snp_valid,
  input logic [1:0]    snp_op,
  input logic          snp_supply,
  input logic [1:0]    snp_next_st,
  input logic          fsm_idle,
  input logic          ev_local_write_hit,
  input logic          ev_wb_done,
  input logic          ev_fill_done
);
  a_r10_read_hit_now: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_idle && cpu_req && !cpu_we && cpu_lstate != 2'd0 && !snp_valid) |-> cpu_ready);

  a_r6_dirty_write_local: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_idle && cpu_req && cpu_we && cpu_lstate == 2'd2 && !snp_valid) |-> (cpu_ready && !bus_req));

  a_r6_no_bus_after_local: assert property (@(posedge clk) disable iff (!rst_n)
    ev_local_write_hit |=> !bus_req);

  a_r9_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_idle && snp_valid) |-> !cpu_ready);

  a_r7_supply_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_next_st == 2'd0 && (snp_op == 2'd1 || snp_op == 2'd2)));

  a_r8_wb_same_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op == 2'd3) |-> (bus_addr[IW-1:0] == cpu_addr[IW-1:0] && bus_addr != cpu_addr));

  a_r8_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_done |=> (bus_req == 1'b0));

  a_r2_op_coded: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_op != 2'd0));

  a_r4_fill_kind: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |-> (bus_op == (cpu_we ? 2'd2 : 2'd1)));
endmodule

bind wo_snoop_ctrl wo_snoop_ctrl_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .cpu_lstate(cpu_lstate), .bus_req(bus_req), .bus_op(bus_op),
  .bus_addr(bus_addr), .snp_valid(snp_valid), .snp_op(snp_op), .snp_supply(snp_supply),
  .snp_next_st(snp_next_st), .fsm_idle(fsm_idle), .ev_local_write_hit(ev_local_write_hit),
  .ev_wb_done(ev_wb_done), .ev_fill_done(ev_fill_done)
);

// File: tb/wo_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module wo_snoop_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NL = 4;
  localparam int NC = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n;

  logic          cpu_req [NC];
  logic          cpu_we [NC];
  logic [AW-1:0] cpu_addr [NC];
  logic [DW-1:0] cpu_wdata [NC];
  logic          cpu_ready [NC];
  logic [DW-1:0] cpu_rdata [NC];
  logic [1:0]    cpu_lstate [NC];
  logic          bus_req [NC];
  logic [1:0]    bus_op [NC];
  logic [AW-1:0] bus_addr [NC];
  logic [DW-1:0] bus_wdata [NC];
  logic          bus_done [NC];
  logic [DW-1:0] bus_rdata [NC];
  logic          bus_from_cache [NC];
  logic          snp_valid [NC];
  logic [1:0]    snp_op [NC];
  logic [AW-1:0] snp_addr [NC];
  logic          snp_supply [NC];
  logic [DW-1:0] snp_data [NC];

  for (genvar i = 0; i < NC; i++) begin : g_c
    wo_snoop_ctrl #(.AW(AW), .DW(DW), .NL(NL)) u_wo_snoop_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req[i]), .cpu_we(cpu_we[i]), .cpu_addr(cpu_addr[i]),
      .cpu_wdata(cpu_wdata[i]), .cpu_ready(cpu_ready[i]), .cpu_rdata(cpu_rdata[i]),
      .cpu_lstate(cpu_lstate[i]),
      .bus_req(bus_req[i]), .bus_op(bus_op[i]), .bus_addr(bus_addr[i]),
      .bus_wdata(bus_wdata[i]), .bus_done(bus_done[i]), .bus_rdata(bus_rdata[i]),
      .bus_from_cache(bus_from_cache[i]),
      .snp_valid(snp_valid[i]), .snp_op(snp_op[i]), .snp_addr(snp_addr[i]),
      .snp_supply(snp_supply[i]), .snp_data(snp_data[i])
    );
  end

  logic [DW-1:0] mem [1 << AW];
  int nvec = 0;
  int nerr = 0;
  int cycles = 0;

  logic [DW-1:0] last_rd;
  int            last_nbus, last_nwb, last_cyc;
  logic          last_sup;
  logic [7:0]    last_ops;
  logic [AW-1:0] last_wb_addr;
  logic [DW-1:0] last_wb_data;

  function automatic logic [DW-1:0] mem_init(int a);
    return 16'h5A00 ^ DW'(a * 263);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic state_of(int c, logic [AW-1:0] a, output logic [1:0] s);
    cpu_addr[c] = a;
    #0.1;
    s = cpu_lstate[c];
  endtask

  task automatic clear_bus();
    for (int o = 0; o < NC; o++) begin
      snp_valid[o] = 1'b0; snp_op[o] = 2'd0; snp_addr[o] = '0;
      bus_done[o] = 1'b0; bus_from_cache[o] = 1'b0; bus_rdata[o] = '0;
    end
  endtask

  // bench plays bus and memory for a single processor access
  task automatic access(int c, logic we, logic [AW-1:0] a, logic [DW-1:0] wd);
    logic done;
    logic sup;
    logic [DW-1:0] sd;
    int cyc;
    done = 1'b0; cyc = 0;
    last_nbus = 0; last_nwb = 0; last_sup = 1'b0; last_ops = '0; last_cyc = -1;
    @(negedge clk);
    cpu_req[c] = 1'b1; cpu_we[c] = we; cpu_addr[c] = a; cpu_wdata[c] = wd;
    while (!done && cyc < 40) begin
      #0.5;
      if (bus_req[c]) begin
        for (int o = 0; o < NC; o++) if (o != c) begin
          snp_valid[o] = 1'b1; snp_op[o] = bus_op[c]; snp_addr[o] = bus_addr[c];
        end
        #0.5;
        sup = 1'b0; sd = '0;
        for (int o = 0; o < NC; o++) if (o != c && snp_supply[o]) begin
          sup = 1'b1; sd = snp_data[o];
        end
        if (bus_op[c] == 2'd3) begin
          mem[bus_addr[c]] = bus_wdata[c];
          last_wb_addr = bus_addr[c];
          last_wb_data = bus_wdata[c];
          last_nwb++;
        end
        bus_rdata[c] = sup ? sd : mem[bus_addr[c]];
        bus_from_cache[c] = sup;
        bus_done[c] = 1'b1;
        last_nbus++;
        if (sup) last_sup = 1'b1;
        last_ops = {last_ops[5:0], bus_op[c]};
      end
      #0.5;
      if (cpu_ready[c]) begin
        last_rd = cpu_rdata[c];
        last_cyc = cyc;
        done = 1'b1;
      end
      cyc++;
      @(negedge clk);
      clear_bus();
    end
    cpu_req[c] = 1'b0;
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL access hang: cache %0d addr %0h actual not-ready expected ready", c, a);
    end
  endtask

  initial begin
    logic [1:0] s;
    logic [AW-1:0] wa, wb2;
    logic [DW-1:0] orig;
    rst_n = 1'b0;
    for (int i = 0; i < NC; i++) begin
      cpu_req[i] = 1'b0; cpu_we[i] = 1'b0; cpu_addr[i] = '0; cpu_wdata[i] = '0;
    end
    clear_bus();
    for (int a = 0; a < (1 << AW); a++) mem[a] = mem_init(a);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all lines invalid, bus and ready quiet
    for (int c = 0; c < NC; c++) begin
      for (int a = 0; a < (1 << AW); a++) begin
        state_of(c, AW'(a), s);
        chk("R1", "reset state", 32'(s), 32'd0);
      end
      chk("R1", "reset bus_req", 32'(bus_req[c]), 32'd0);
      chk("R1", "reset cpu_ready", 32'(cpu_ready[c]), 32'd0);
    end

    wa = 8'h15;
    wb2 = wa + 8'(NL);
    orig = mem_init(wa);

    // R2: first reader fills clean from memory
    access(1, 1'b0, wa, '0);
    chk("R2", "read data", 32'(last_rd), 32'(orig));
    chk("R2", "bus count", 32'(last_nbus), 32'd1);
    chk("R2", "bus op", 32'(last_ops[1:0]), 32'd1);
    state_of(1, wa, s); chk("R2", "state", 32'(s), 32'd1);

    // R3: second reader, clean holder stays silent
    access(0, 1'b0, wa, '0);
    chk("R3", "no supply", 32'(last_sup), 32'd0);
    chk("R3", "memory data", 32'(last_rd), 32'(orig));
    state_of(1, wa, s); chk("R3", "holder clean", 32'(s), 32'd1);
    state_of(0, wa, s); chk("R2", "reader clean", 32'(s), 32'd1);

    // R4 / R5: write to clean line
    access(0, 1'b1, wa, 16'hBEE2);
    chk("R4", "bus count", 32'(last_nbus), 32'd1);
    chk("R4", "bus op rdx", 32'(last_ops[1:0]), 32'd2);
    chk("R4", "no writeback", 32'(last_nwb), 32'd0);
    chk("R4", "memory stale", 32'(mem[wa]), 32'(orig));
    state_of(0, wa, s); chk("R4", "writer dirty", 32'(s), 32'd2);
    state_of(1, wa, s); chk("R5", "clean copy dropped", 32'(s), 32'd0);

    // R6: repeated write stays local; R10 read hit
    access(0, 1'b1, wa, 16'hC0D3);
    chk("R6", "no bus", 32'(last_nbus), 32'd0);
    chk("R6", "same cycle", 32'(last_cyc), 32'd0);
    access(0, 1'b0, wa, '0);
    chk("R10", "hit data", 32'(last_rd), 32'hC0D3);
    chk("R10", "hit no bus", 32'(last_nbus), 32'd0);
    chk("R10", "hit same cycle", 32'(last_cyc), 32'd0);

    // R7: third party reads; owner intervenes
    access(2, 1'b0, wa, '0);
    chk("R7", "supplied", 32'(last_sup), 32'd1);
    chk("R7", "intervened data", 32'(last_rd), 32'hC0D3);
    chk("R7", "memory untouched", 32'(mem[wa]), 32'(orig));
    state_of(2, wa, s); chk("R7", "reader dirty", 32'(s), 32'd2);
    state_of(0, wa, s); chk("R7", "owner invalid", 32'(s), 32'd0);

    // R7: third party writes; ownership moves again
    access(1, 1'b1, wa, 16'h4444);
    chk("R7", "write supplied", 32'(last_sup), 32'd1);
    state_of(1, wa, s); chk("R7", "writer dirty", 32'(s), 32'd2);
    state_of(2, wa, s); chk("R7", "old owner invalid", 32'(s), 32'd0);

    // R8: dirty victim written back before fill
    access(1, 1'b1, wb2, 16'h5555);
    chk("R8", "writeback count", 32'(last_nwb), 32'd1);
    chk("R8", "op order", 32'(last_ops[3:0]), 32'hE);
    chk("R8", "wb addr", 32'(last_wb_addr), 32'(wa));
    chk("R8", "wb data", 32'(last_wb_data), 32'h4444);
    chk("R8", "memory updated", 32'(mem[wa]), 32'h4444);
    state_of(1, wb2, s); chk("R8", "new line dirty", 32'(s), 32'd2);
    state_of(1, wa, s); chk("R8", "old line gone", 32'(s), 32'd0);

    // R8: clean victim silent
    access(0, 1'b0, 8'h22, '0);
    access(0, 1'b0, 8'h26, '0);
    chk("R8", "clean evict one op", 32'(last_nbus), 32'd1);
    chk("R8", "clean evict no wb", 32'(last_nwb), 32'd0);
    chk("R8", "clean evict data", 32'(last_rd), 32'(mem_init(8'h26)));

    // R9: snoop in the request cycle delays a hit by one cycle
    @(negedge clk);
    cpu_req[1] = 1'b1; cpu_we[1] = 1'b0; cpu_addr[1] = wb2;
    snp_valid[1] = 1'b1; snp_op[1] = 2'd1; snp_addr[1] = 8'h03;
    #0.5;
    chk("R9", "held during snoop", 32'(cpu_ready[1]), 32'd0);
    @(negedge clk);
    clear_bus();
    #0.5;
    chk("R9", "completes after", 32'(cpu_ready[1]), 32'd1);
    chk("R9", "data after", 32'(cpu_rdata[1]), 32'h5555);
    @(negedge clk);
    cpu_req[1] = 1'b0;

    // sweep: writer then reader across shared frames (R4, R7, R8)
    for (int k = 0; k < 48; k++) begin
      int w, r;
      logic [AW-1:0] a;
      logic [DW-1:0] v;
      w = k % NC;
      r = (k + 1) % NC;
      a = AW'(8'h40 + k);
      v = DW'(k * 273 + 7);
      access(w, 1'b1, a, v);
      state_of(w, a, s); chk("R4", "sweep writer dirty", 32'(s), 32'd2);
      access(r, 1'b0, a, '0);
      chk("R7", "sweep data", 32'(last_rd), 32'(v));
      chk("R7", "sweep supply", 32'(last_sup), 32'd1);
      state_of(r, a, s); chk("R7", "sweep reader dirty", 32'(s), 32'd2);
      state_of(w, a, s); chk("R7", "sweep writer invalid", 32'(s), 32'd0);
      if (last_nwb != 0)
        chk("R8", "sweep wb frame", 32'(last_wb_addr[1:0]), 32'(a[1:0]));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule